// File: doc/BRIEF.md
# Byte-Wide Asynchronous ROM Read Controller

This block sits between an on-chip request/response port and an external, byte-wide asynchronous read-only memory with 2^20 locations. A requester offers a 20-bit address with a ready/valid handshake. The controller latches the address, drives it to the memory and asserts both enables. It then counts a fixed number of clock cycles, captures the data bus and returns the byte with a one-cycle valid pulse.

The wait count is worked out at elaboration time from the clock period and three access limits: address to data, chip-enable to data and output-enable to data. Each limit is divided by the period and rounded up, and the largest result is used. Between reads the chip-enable is released, which keeps the memory in its low-power standby state. After each read the controller holds off for a float gap, so the memory's outputs reach high impedance before the shared data bus is reported free to other drivers. A parameter sets the active level of the output-enable pin.

Top module: `rom_rd_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After that edge, `rom_addr` equals the accepted address and both enables are asserted.
- R2: `rom_ce_n` is active low. It is high out of reset and at all times while `req_ready` is high, so the memory stays in standby when no read is in progress.
- R3: With `OE_ACTIVE_HIGH` = 0, `rom_oe` is 0 when asserted and 1 otherwise. With `OE_ACTIVE_HIGH` = 1, the levels are the other way round. In both cases `rom_oe` is asserted exactly while `rom_ce_n` is low.
- R4: The access count N is the largest of ceil(T_ADDR_NS/CLK_NS), ceil(T_CE_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS). The data bus is captured on the N-th clock edge after the edge that asserts the enables, never earlier. With the defaults (4 ns, 100/100/80 ns), N = 25.
- R5: `rsp_valid` rises right after the capture edge and stays high for exactly one cycle. While it is high, `rsp_data` holds the byte that was on `rom_dq` at that edge.
- R6: `rom_addr` does not change on any cycle where `rom_ce_n` is low.
- R7: The enables deassert on the edge that ends the `rsp_valid` cycle. `bus_free` then stays low for F = ceil(T_FLOAT_NS/CLK_NS) cycles (5 with the defaults) and rises after that. `bus_free` is never high while `rom_ce_n` is low.
- R8: When requests are offered back to back, consecutive falling edges of `rom_ce_n` are exactly N + F + 2 cycles apart. This spacing is never below the cycle-time limit.
- R9: While `req_ready` is low, a pending request has no effect: `rom_addr` keeps its value on the next cycle. The request is served only after the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 20 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rsp_data | output | 8 | Byte captured from the memory |
| bus_free | output | 1 | Memory outputs have floated; other drivers may use the bus |
| rom_addr | output | 20 | Address lines to the memory |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe | output | 1 | Output enable, level set by OE_ACTIVE_HIGH |
| rom_dq | input | 8 | Data lines from the memory |

## Verification
The bound checker evaluates on every clock cycle that the chip-enable stays high when idle, that the output-enable follows it at the configured level, that the address holds still while the device is selected, and that the data is captured exactly N selected cycles after the enables assert. It also checks that `rsp_valid` is a single pulse, that a busy controller ignores requests, and that the bus is reported free only after F deselected cycles. Only the bench scenarios can show three further things: that the returned byte is the right one for several address patterns (the memory model returns wrong data if it is sampled before any of its three access times), the exact back-to-back spacing between accesses, and the behaviour of the inverted output-enable polarity alongside the default.

// File: rtl/rom_rd_pkg.sv
// Shared types and elaboration-time helpers for the ROM read controller.
// Assumes all times are given in whole nanoseconds and are non-negative.
package rom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_SAMPLE  = 3'd3,
        ST_RELEASE = 3'd4
    } rd_state_e;

    // Whole clock cycles that cover a time span (rounded up).
    function automatic int unsigned cyc_ceil(input int unsigned span_ns,
                                             input int unsigned period_ns);
        return (span_ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two counts.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_rd_timer.sv
// Down-counter used for both the access wait and the float gap.
// Loads a value and then decrements once per cycle until it reaches zero.
// 'last' is high on the final cycle of a loaded interval (count == 1).
// Assumes the loader never loads zero (the sequencer skips zero-length states).
module rom_rd_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final cycle of the loaded interval.
    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/rom_rd_seq.sv
// Access sequencer: IDLE -> SETUP -> WAIT -> SAMPLE -> RELEASE -> IDLE.
// SETUP plus WAIT span exactly ACC_CYC cycles. The data capture strobe fires
// on the edge that enters SAMPLE. RELEASE spans FLOAT_CYC cycles.
// Assumes ACC_CYC >= 1. A zero-length WAIT or RELEASE is skipped.
module rom_rd_seq
    import rom_rd_pkg::*;
#(
    parameter int unsigned ACC_CYC   = 25,
    parameter int unsigned FLOAT_CYC = 5,
    parameter int unsigned CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          tmr_last,
    output rd_state_e     state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          capture
);

    localparam int unsigned WAIT_CYC = ACC_CYC - 1;

    rd_state_e state_q, state_d;

    // Next-state, timer load and capture decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (WAIT_CYC == 0) begin
                    state_d = ST_SAMPLE;
                    capture = 1'b1;
                end else begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WAIT_CYC);
                end
            end
            ST_WAIT: begin
                if (tmr_last) begin
                    state_d = ST_SAMPLE;
                    capture = 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (FLOAT_CYC == 0) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(FLOAT_CYC);
                end
            end
            ST_RELEASE: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/rom_rd_ctrl.sv
// Top level: serves single-byte reads from an asynchronous parallel ROM.
// Latches the address on acceptance, drives the enables during SETUP/WAIT/
// SAMPLE, captures the data bus after the derived access count and reports
// the bus free once the float gap has elapsed.
// Assumes the memory's cycle time equals its address access time.
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned CLK_NS         = 4,
    parameter int unsigned T_ADDR_NS      = 100,
    parameter int unsigned T_CE_NS        = 100,
    parameter int unsigned T_OE_NS        = 80,
    parameter int unsigned T_FLOAT_NS     = 20,
    parameter bit          OE_ACTIVE_HIGH = 1'b0,
    parameter int unsigned AW             = 20,
    parameter int unsigned DW             = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          bus_free,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe,
    input  logic [DW-1:0] rom_dq
);

    localparam int unsigned ACC_CYC = umax(1, umax(cyc_ceil(T_ADDR_NS, CLK_NS),
                                              umax(cyc_ceil(T_CE_NS, CLK_NS),
                                                   cyc_ceil(T_OE_NS, CLK_NS))));
    localparam int unsigned FLOAT_CYC = cyc_ceil(T_FLOAT_NS, CLK_NS);
    localparam int unsigned MAX_CNT   = umax(1, umax(ACC_CYC, FLOAT_CYC));
    localparam int unsigned CW        = $clog2(MAX_CNT + 1);

    rd_state_e     state;
    logic          tmr_load, tmr_last, capture, selected, accept;
    logic [CW-1:0] tmr_val;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    rom_rd_seq #(
        .ACC_CYC  (ACC_CYC),
        .FLOAT_CYC(FLOAT_CYC),
        .CW       (CW)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .tmr_last (tmr_last),
        .state    (state),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture)
    );

    rom_rd_timer #(
        .CW(CW)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign selected  = (state == ST_SETUP) || (state == ST_WAIT) || (state == ST_SAMPLE);

    // Address latch: loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    // Data capture on the edge that enters SAMPLE.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= rom_dq;
    end

    assign rom_addr  = addr_q;
    assign rom_ce_n  = !selected;
    assign rsp_valid = (state == ST_SAMPLE);
    assign rsp_data  = data_q;
    assign bus_free  = (state == ST_IDLE);

    // Output-enable level chosen by parameter.
    generate
        if (OE_ACTIVE_HIGH) begin : g_oe_high
            assign rom_oe = selected;
        end else begin : g_oe_low
            assign rom_oe = !selected;
        end
    endgenerate

endmodule

// File: rtl/rom_rd_ctrl_chk.sv
// Cycle-level checker for rom_rd_ctrl, bound into every instance.
// Keeps its own counters of selected and deselected cycles. It compares them
// with the access count and the float gap without looking inside the design.
module rom_rd_ctrl_chk #(
    parameter int unsigned N_CYC          = 25,
    parameter int unsigned F_CYC          = 5,
    parameter bit          OE_ACTIVE_HIGH = 1'b0,
    parameter int unsigned AW             = 20,
    parameter int unsigned DW             = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          bus_free,
    input logic [AW-1:0] rom_addr,
    input logic          rom_ce_n,
    input logic          rom_oe,
    input logic [DW-1:0] rom_dq
);

    localparam logic OE_ON = OE_ACTIVE_HIGH ? 1'b1 : 1'b0;
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] lo_cnt, hi_cnt;

    // Count consecutive cycles with chip-enable low, and with it high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= SAT;
        end else begin
            lo_cnt <= rom_ce_n ? 16'd0 : ((lo_cnt == SAT) ? SAT : lo_cnt + 16'd1);
            hi_cnt <= !rom_ce_n ? 16'd0 : ((hi_cnt == SAT) ? SAT : hi_cnt + 16'd1);
        end
    end

    assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rom_ce_n && rom_addr == $past(req_addr)));

    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> rom_ce_n);

    assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> (rom_oe == OE_ON));

    assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> (rom_oe != OE_ON));

    assert_sample_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!rom_ce_n && lo_cnt == 16'(N_CYC)));

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !$past(rom_ce_n)) |-> $stable(rom_addr));

    assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> (rom_ce_n && hi_cnt >= 16'(F_CYC)));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(rom_addr));

endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
    .N_CYC         (ACC_CYC),
    .F_CYC         (FLOAT_CYC),
    .OE_ACTIVE_HIGH(OE_ACTIVE_HIGH),
    .AW            (AW),
    .DW            (DW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .bus_free (bus_free),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe   (rom_oe),
    .rom_dq   (rom_dq)
);

// File: tb/rom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for rom_rd_ctrl. It models the memory with age counters and
// returns corrupted data if any access time has not yet elapsed at the capture edge.
module rom_rd_ctrl_tb_top;

    localparam int CLK   = 4;
    localparam int T_AD  = 100;
    localparam int T_CE  = 100;
    localparam int T_OE  = 80;
    localparam int T_FL  = 20;

    function automatic int up_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int EXP_N = (up_div(T_AD, CLK) > up_div(T_CE, CLK))
                         ? ((up_div(T_AD, CLK) > up_div(T_OE, CLK)) ? up_div(T_AD, CLK) : up_div(T_OE, CLK))
                         : ((up_div(T_CE, CLK) > up_div(T_OE, CLK)) ? up_div(T_CE, CLK) : up_div(T_OE, CLK));
    localparam int EXP_F = up_div(T_FL, CLK);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready, rsp_valid, bus_free, rom_ce_n, rom_oe;
    logic [7:0]  rsp_data, rom_dq;
    logic [19:0] rom_addr;
    logic        h_ready, h_rvalid, h_free, h_ce_n, h_oe;
    logic [7:0]  h_data;
    logic [19:0] h_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK/2) clk = ~clk;

    rom_rd_ctrl #(.CLK_NS(CLK), .T_ADDR_NS(T_AD), .T_CE_NS(T_CE), .T_OE_NS(T_OE),
                  .T_FLOAT_NS(T_FL), .OE_ACTIVE_HIGH(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_free(bus_free), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe(rom_oe), .rom_dq(rom_dq));

    // Second instance with the inverted output-enable level, same stimulus.
    rom_rd_ctrl #(.CLK_NS(CLK), .T_ADDR_NS(T_AD), .T_CE_NS(T_CE), .T_OE_NS(T_OE),
                  .T_FLOAT_NS(T_FL), .OE_ACTIVE_HIGH(1'b1)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(h_ready),
        .req_addr(req_addr), .rsp_valid(h_rvalid), .rsp_data(h_data),
        .bus_free(h_free), .rom_addr(h_addr), .rom_ce_n(h_ce_n),
        .rom_oe(h_oe), .rom_dq(rom_dq));

    function automatic logic [7:0] rom_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    // Memory model: ages count whole cycles since each input last became valid.
    int ce_age = 0, oe_age = 0, ad_age = 0, hi_age = 1000;
    logic [19:0] ad_seen = '1;
    always @(posedge clk) begin
        ce_age <= rom_ce_n ? 0 : ce_age + 1;
        oe_age <= rom_oe ? 0 : oe_age + 1;
        hi_age <= rom_ce_n ? hi_age + 1 : 0;
        ad_seen <= rom_addr;
        ad_age <= (rom_addr !== ad_seen) ? 1 : ad_age + 1;
    end
    assign rom_dq = (((ce_age + 1) * CLK >= T_CE) && ((oe_age + 1) * CLK >= T_OE) &&
                     ((ad_age + 1) * CLK >= T_AD)) ? rom_byte(rom_addr) : ~rom_byte(rom_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7: continuous float-gap monitor on the bus release.
    always @(negedge clk) begin
        if (rst_n && bus_free && (hi_age * CLK < T_FL)) begin
            n_bad++;
            $display("FAIL R7 bus freed early actual=%0d expected>=%0d", hi_age * CLK, T_FL);
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(rom_ce_n == 1'b1, "R2 standby after reset", 32'(rom_ce_n), 1);
        chk(rom_oe == 1'b1 && h_oe == 1'b0, "R3 oe idle levels", {rom_oe, h_oe}, 32'b10);
        chk(bus_free == 1'b1 && rsp_valid == 1'b0, "R7 bus free, no response", {bus_free, rsp_valid}, 32'b10);
    endtask

    task automatic t_single(input logic [19:0] a);
        int cyc;
        bit moved;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rom_ce_n == 1'b0 && rom_addr == a && !req_ready, "R1 accept starts access",
            {rom_ce_n, rom_addr}, {1'b0, a});
        chk(rom_oe == 1'b0 && h_oe == 1'b1, "R3 oe asserted levels", {rom_oe, h_oe}, 32'b01);
        cyc = 0;
        moved = 1'b0;
        while (!rsp_valid && cyc < 500) begin
            if (rom_addr != a) moved = 1'b1;
            @(negedge clk);
            cyc++;
        end
        chk(!moved, "R6 address held while selected", 32'(moved), 0);
        chk(cyc == EXP_N, "R4 capture cycle", cyc, EXP_N);
        chk(rsp_data == rom_byte(a), "R5 returned byte", rsp_data, rom_byte(a));
        @(negedge clk);
        chk(!rsp_valid && rom_ce_n && !bus_free, "R5 R7 pulse ends, release starts",
            {rsp_valid, rom_ce_n, bus_free}, 32'b010);
        cyc = 0;
        while (!bus_free && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == EXP_F, "R7 float gap cycles", cyc, EXP_F);
        chk(req_ready && rom_ce_n, "R2 standby after read", {req_ready, rom_ce_n}, 32'b11);
    endtask

    task automatic t_busy(input logic [19:0] a, input logic [19:0] b);
        int idx, fall1, fall2, nrsp;
        logic prev_ce;
        logic [7:0] d1, d2;
        bit moved;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_addr = b;
        idx = 0; fall1 = -1; fall2 = -1; nrsp = 0; prev_ce = 1'b1; moved = 1'b0;
        d1 = '0; d2 = '0;
        while (nrsp < 2 && idx < 1000) begin
            if (prev_ce && !rom_ce_n) begin
                if (fall1 < 0) fall1 = idx;
                else begin
                    fall2 = idx;
                    req_valid = 1'b0;
                end
            end
            if (fall2 < 0 && rom_addr != a) moved = 1'b1;
            if (rsp_valid) begin
                if (nrsp == 0) d1 = rsp_data; else d2 = rsp_data;
                nrsp++;
            end
            prev_ce = rom_ce_n;
            @(negedge clk);
            idx++;
        end
        req_valid = 1'b0;
        chk(!moved, "R9 pending request ignored while busy", 32'(moved), 0);
        chk(fall2 - fall1 == EXP_N + EXP_F + 2, "R8 back-to-back spacing", fall2 - fall1, EXP_N + EXP_F + 2);
        chk(d1 == rom_byte(a), "R5 first byte", d1, rom_byte(a));
        chk(d2 == rom_byte(b), "R5 second byte", d2, rom_byte(b));
        while (!bus_free) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(20'h12345);
        t_single(20'h00000);
        t_single(20'hFFFFF);
        t_single(20'hAAAAA);
        t_single(20'h55555);
        t_busy(20'h0F0F0, 20'hC3A51);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 run did not complete actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule